// File: doc/BRIEF.md
# Periodic Temperature Conversion Scheduler

This block paces the conversions of an on-chip temperature converter. A prescaler turns the system clock into a slow tick. A phase counter counts ticks across one conversion period. At the start of each period the block raises the analog enable, which powers the converter's analog section. It keeps the enable high for a fixed number of ticks. At the end of that window it takes the converter's result into a pending buffer, provided the converter marks the result valid. The analog section then stays off for the rest of the period.

The pending result is copied into the readable temperature value only while the serial bus is idle, so a read already in progress returns the older value. If the bus stays busy until the period ends, the pending result is discarded and the next conversion begins. The end of any bus transaction restarts the timebase and starts a fresh conversion. If a result is pending at that moment, it is committed on the same edge.

A shutdown bit written through the configuration path stops all conversions and keeps the last value readable. Shutdown cannot be entered while any lock is set, but it can be left at any time. Leaving shutdown starts a conversion at once.

The control is a four-state machine:
- OFF: shut down, analog off, timebase held at zero.
- CONV: converting, analog on.
- PEND: result held, waiting for an idle bus.
- GAP: analog off until the period ends.

Transitions:
- OFF→CONV when shutdown is cleared.
- Any→OFF when shutdown is accepted.
- CONV→PEND at the end of the window with a valid result.
- CONV→GAP at the end of the window without a valid result.
- PEND→GAP on commit.
- PEND→CONV on commit at the period end, on a drop at the period end, or on a transaction end.
- GAP→CONV at the period end.
- CONV→CONV when a transaction end restarts the conversion.

Top module: `conv_sched`

## Requirements
- R1: After reset the block is not shut down, `analog_en` is 1 in the first cycle, `temp_value` is 0 and `temp_upd` is 0.
- R2: A conversion keeps `analog_en` high for exactly CONV_TICKS×TICK_DIV cycles. The next conversion starts PERIOD_TICKS×TICK_DIV cycles after the previous one started, unless a restart or shutdown intervenes.
- R3: On the last cycle of a conversion window, if `adc_valid` is 1 then `adc_result` is captured. With the bus idle, `temp_value` takes the captured result one cycle later, together with a one-cycle `temp_upd`. If `adc_valid` is 0, `temp_value` is left unchanged.
- R4: While `bus_busy` is 1 and `bus_done` is 0, a pending result is not committed. It is committed on the first cycle in the same period in which `bus_busy` is 0.
- R5: If `bus_busy` stays 1 up to the last cycle of the period, the pending result is dropped, `temp_value` is left unchanged and a new conversion starts.
- R6: A one-cycle `bus_done` pulse outside shutdown restarts the timebase: `analog_en` is 1 from the next cycle for a full conversion window. A result pending at that moment is committed on the same edge.
- R7: A write with `cfg_wr`=1 and `cfg_shdn`=1 while `lock_any`=0 drops `analog_en` in the next cycle. `analog_en` stays low and `temp_value` stays unchanged, with no `temp_upd`, for as long as shutdown lasts.
- R8: A write with `cfg_shdn`=1 is ignored while `lock_any`=1. A write with `cfg_shdn`=0 leaves shutdown whatever `lock_any` is, and `analog_en` is 1 in the next cycle.
- R9: `temp_upd` is never high for two cycles in a row, and `temp_value` changes only in a cycle where `temp_upd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | One-cycle strobe: the configuration shutdown bit is being written |
| cfg_shdn | input | 1 | Value written to the shutdown bit (1 = shut down) |
| lock_any | input | 1 | 1 while any configuration lock is set |
| bus_busy | input | 1 | 1 while a serial bus transaction addressed to the device is in progress |
| bus_done | input | 1 | One-cycle pulse at the end of a bus read or write |
| adc_result | input | RES_W | Converter result, signed two's complement |
| adc_valid | input | 1 | Converter result is valid |
| analog_en | output | 1 | Powers the analog section and requests a conversion |
| temp_value | output | RES_W | Committed temperature value |
| temp_upd | output | 1 | One-cycle strobe when `temp_value` is updated |

## Verification
The assertions assume that `bus_done` is a single-cycle pulse and that `cfg_wr` is a single-cycle strobe. They also assume that the parameters satisfy CONV_TICKS < PERIOD_TICKS. The window-length check additionally depends on `analog_en` being lowered or restarted only through the ports. The stimulus drives every strobe high for exactly one clock, at a falling edge. It holds `adc_result` and `adc_valid` steady across each conversion boundary. It restarts the timebase with `bus_done` before each scenario, so that each scenario's cycle counts start from a known phase.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_CONV = 2'd1,
        S_PEND = 2'd2,
        S_GAP  = 2'd3
    } sched_state_e;

endpackage

// File: rtl/conv_tick_gen.sv
module conv_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/conv_phase_ctr.sv
module conv_phase_ctr #(
    parameter int PERIOD_TICKS = 100,
    parameter int CONV_TICKS   = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic conv_end,
    output logic period_end
);
    localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(PERIOD_TICKS - 1);
    localparam logic [PW-1:0] C_LAST = PW'(CONV_TICKS - 1);

    logic [PW-1:0] ph_q;

    assign conv_end   = tick && (ph_q == C_LAST);
    assign period_end = tick && (ph_q == P_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (restart || period_end) begin
            ph_q <= '0;
        end else if (tick) begin
            ph_q <= ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/conv_shdn_ctl.sv
module conv_shdn_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_shdn,
    input  logic lock_any,
    output logic shdn_nx,
    output logic shdn_q
);
    always_comb begin
        shdn_nx = shdn_q;
        if (cfg_wr) begin
            if (!cfg_shdn) begin
                shdn_nx = 1'b0;
            end else if (!lock_any) begin
                shdn_nx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shdn_q <= 1'b0;
        end else begin
            shdn_q <= shdn_nx;
        end
    end
endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int TICK_DIV     = 100000,
    parameter int PERIOD_TICKS = 100,
    parameter int CONV_TICKS   = 60,
    parameter int RES_W        = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_shdn,
    input  logic             lock_any,
    input  logic             bus_busy,
    input  logic             bus_done,
    input  logic [RES_W-1:0] adc_result,
    input  logic             adc_valid,
    output logic             analog_en,
    output logic [RES_W-1:0] temp_value,
    output logic             temp_upd
);
    sched_state_e     state_q, state_d;
    logic             tick, conv_end, period_end, restart;
    logic             shdn_nx, shdn_q;
    logic             capture, commit;
    logic [RES_W-1:0] pend_q;

    assign restart = bus_done || (state_q == S_OFF);

    conv_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    conv_phase_ctr #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .CONV_TICKS   (CONV_TICKS)
    ) phase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .tick       (tick),
        .conv_end   (conv_end),
        .period_end (period_end)
    );

    conv_shdn_ctl shdn_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_shdn (cfg_shdn),
        .lock_any (lock_any),
        .shdn_nx  (shdn_nx),
        .shdn_q   (shdn_q)
    );

    // Next-state decision and the capture / commit requests
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        commit  = 1'b0;
        if (shdn_nx) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF: begin
                    state_d = S_CONV;
                end
                S_CONV: begin
                    if (bus_done) begin
                        state_d = S_CONV;
                    end else if (conv_end) begin
                        capture = adc_valid;
                        state_d = adc_valid ? S_PEND : S_GAP;
                    end
                end
                S_PEND: begin
                    if (bus_done) begin
                        commit  = 1'b1;
                        state_d = S_CONV;
                    end else if (!bus_busy) begin
                        commit  = 1'b1;
                        state_d = period_end ? S_CONV : S_GAP;
                    end else if (period_end) begin
                        state_d = S_CONV;
                    end
                end
                S_GAP: begin
                    if (bus_done || period_end) begin
                        state_d = S_CONV;
                    end
                end
                default: state_d = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_CONV;
        end else begin
            state_q <= state_d;
        end
    end

    // Pending result buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (capture) begin
            pend_q <= adc_result;
        end
    end

    // Outputs
    assign analog_en = (state_q == S_CONV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_value <= '0;
            temp_upd   <= 1'b0;
        end else begin
            temp_upd <= commit;
            if (commit) begin
                temp_value <= pend_q;
            end
        end
    end
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk
    import conv_sched_pkg::*;
#(
    parameter int TICK_DIV   = 100000,
    parameter int CONV_TICKS = 60,
    parameter int RES_W      = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_shdn,
    input logic             lock_any,
    input logic             bus_busy,
    input logic             bus_done,
    input logic             analog_en,
    input logic [RES_W-1:0] temp_value,
    input logic             temp_upd,
    input sched_state_e     state_q,
    input logic             shdn_nx
);
    localparam logic [31:0] CONV_CYC = 32'(TICK_DIV * CONV_TICKS);

    logic [31:0] en_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_run <= '0;
        end else if (analog_en && !bus_done) begin
            en_run <= en_run + 1'b1;
        end else begin
            en_run <= '0;
        end
    end

    // R2
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        analog_en |-> (en_run < CONV_CYC));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !bus_done) |=> !temp_upd);

    // R6
    restart_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done && state_q != S_OFF && !shdn_nx) |=> analog_en);

    // R7
    shdn_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_shdn && !lock_any) |=> !analog_en);

    // R8
    shdn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && cfg_wr && !cfg_shdn) |=> analog_en);

    // R8
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_OFF && lock_any && cfg_wr) |=> (state_q != S_OFF));

    // R9
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp_upd |=> !temp_upd);

    // R9
    value_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(temp_value) |-> temp_upd);
endmodule

bind conv_sched conv_sched_chk #(
    .TICK_DIV   (TICK_DIV),
    .CONV_TICKS (CONV_TICKS),
    .RES_W      (RES_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_shdn   (cfg_shdn),
    .lock_any   (lock_any),
    .bus_busy   (bus_busy),
    .bus_done   (bus_done),
    .analog_en  (analog_en),
    .temp_value (temp_value),
    .temp_upd   (temp_upd),
    .state_q    (state_q),
    .shdn_nx    (shdn_nx)
);

// File: tb/conv_sched_tb.sv
module conv_sched_tb_top;
    localparam int D  = 3;
    localparam int C  = 6;
    localparam int P  = 10;
    localparam int W  = 13;
    localparam int CD = C * D;
    localparam int PD = P * D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0, cfg_shdn = 1'b0, lock_any = 1'b0;
    logic         bus_busy = 1'b0, bus_done = 1'b0;
    logic [W-1:0] adc_result = '0;
    logic         adc_valid = 1'b1;
    logic         analog_en, temp_upd;
    logic [W-1:0] temp_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    conv_sched #(.TICK_DIV(D), .PERIOD_TICKS(P), .CONV_TICKS(C), .RES_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_shdn(cfg_shdn),
        .lock_any(lock_any), .bus_busy(bus_busy), .bus_done(bus_done),
        .adc_result(adc_result), .adc_valid(adc_valid),
        .analog_en(analog_en), .temp_value(temp_value), .temp_upd(temp_upd)
    );

    // Behavioural reference: mode 0 off, 1 converting, 2 holding, 3 idle gap
    int           m_mode, m_el;
    bit           m_shdn, m_upd, nshdn, endp;
    logic [W-1:0] m_val, m_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_el = 0; m_shdn = 0; m_upd = 0; m_val = '0; m_pend = '0;
        end else begin
            nshdn = m_shdn;
            if (cfg_wr) begin
                if (!cfg_shdn) nshdn = 0;
                else if (!lock_any) nshdn = 1;
            end
            m_upd = 0;
            if (nshdn) begin
                m_mode = 0; m_el = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_el = 0;
            end else if (bus_done) begin
                if (m_mode == 2) begin m_val = m_pend; m_upd = 1; end
                m_mode = 1; m_el = 0;
            end else begin
                endp = (m_el == PD - 1);
                if (m_mode == 1) begin
                    if (m_el == CD - 1) begin
                        if (adc_valid) begin m_pend = adc_result; m_mode = 2; end
                        else m_mode = 3;
                    end
                end else if (m_mode == 2) begin
                    if (!bus_busy) begin
                        m_val = m_pend; m_upd = 1; m_mode = endp ? 1 : 3;
                    end else if (endp) begin
                        m_mode = 1;
                    end
                end else if (endp) begin
                    m_mode = 1;
                end
                m_el = endp ? 0 : m_el + 1;
            end
            m_shdn = nshdn;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(analog_en === (m_mode == 1), "R2 analog_en vs model", analog_en, (m_mode == 1));
            chk(temp_value === m_val, "R3 temp_value vs model", temp_value, m_val);
            chk(temp_upd === m_upd, "R9 temp_upd vs model", temp_upd, m_upd);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart_tb();
        bus_done = 1'b1;
        step(1);
        bus_done = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        adc_result = 13'h0150;
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        chk(analog_en === 1'b1, "R1 analog_en after reset", analog_en, 1);
        chk(temp_value === '0, "R1 temp_value after reset", temp_value, 0);
        chk(temp_upd === 1'b0, "R1 temp_upd after reset", temp_upd, 0);
        // R2 / R3 plain conversion with idle bus
        step(17);
        chk(analog_en === 1'b1, "R2 last conversion cycle", analog_en, 1);
        step(1);
        chk(analog_en === 1'b0, "R2 window ends", analog_en, 0);
        step(1);
        chk(temp_upd === 1'b1, "R3 update strobe", temp_upd, 1);
        chk(temp_value === 13'h0150, "R3 captured value", temp_value, 13'h0150);
        step(1);
        chk(temp_upd === 1'b0, "R9 strobe one cycle", temp_upd, 0);
        step(10);
        chk(analog_en === 1'b1, "R2 next period starts", analog_en, 1);

        // R6 restart, R4 held while busy
        adc_result = 13'h1F80;
        restart_tb();
        chk(analog_en === 1'b1, "R6 restart converts", analog_en, 1);
        bus_busy = 1'b1;
        step(22);
        chk(temp_value === 13'h0150, "R4 held while busy", temp_value, 13'h0150);
        bus_busy = 1'b0;
        step(1);
        chk(temp_upd === 1'b1, "R4 commit when idle", temp_upd, 1);
        chk(temp_value === 13'h1F80, "R4 committed value", temp_value, 13'h1F80);

        // R5 drop at period end
        adc_result = 13'h00A0;
        restart_tb();
        bus_busy = 1'b1;
        step(30);
        chk(analog_en === 1'b1, "R5 new conversion after drop", analog_en, 1);
        chk(temp_value === 13'h1F80, "R5 dropped result", temp_value, 13'h1F80);
        bus_busy = 1'b0;
        step(19);
        chk(temp_value === 13'h00A0, "R5 following conversion", temp_value, 13'h00A0);

        // R6 transaction end commits pending result
        adc_result = 13'h0333;
        restart_tb();
        bus_busy = 1'b1;
        step(19);
        bus_done = 1'b1;
        step(1);
        bus_done = 1'b0;
        bus_busy = 1'b0;
        chk(temp_upd === 1'b1, "R6 commit on bus_done", temp_upd, 1);
        chk(temp_value === 13'h0333, "R6 committed value", temp_value, 13'h0333);
        chk(analog_en === 1'b1, "R6 conversion restarted", analog_en, 1);

        // R3 invalid result not taken
        adc_valid = 1'b0;
        adc_result = 13'h0444;
        restart_tb();
        step(20);
        chk(temp_value === 13'h0333, "R3 invalid result ignored", temp_value, 13'h0333);
        adc_valid = 1'b1;

        // R7 shutdown
        adc_result = 13'h0077;
        restart_tb();
        step(5);
        cfg_wr = 1'b1; cfg_shdn = 1'b1;
        step(1);
        cfg_wr = 1'b0;
        chk(analog_en === 1'b0, "R7 shutdown stops analog", analog_en, 0);
        step(40);
        chk(analog_en === 1'b0, "R7 stays shut down", analog_en, 0);
        chk(temp_value === 13'h0333, "R7 value retained", temp_value, 13'h0333);

        // R8 leave shutdown while locked, locked set ignored
        lock_any = 1'b1;
        cfg_wr = 1'b1; cfg_shdn = 1'b0;
        step(1);
        cfg_wr = 1'b0;
        chk(analog_en === 1'b1, "R8 clear under lock", analog_en, 1);
        step(5);
        cfg_wr = 1'b1; cfg_shdn = 1'b1;
        step(1);
        cfg_wr = 1'b0;
        chk(analog_en === 1'b1, "R8 locked shutdown ignored", analog_en, 1);
        step(13);
        chk(temp_value === 13'h0077, "R8 conversion completes under lock", temp_value, 13'h0077);
        lock_any = 1'b0;
        step(5);
        finish_run();
    end
endmodule